// File: doc/BRIEF.md
# Quad DAC Serial Command Decoder

This block is the digital control core of a four-channel, 10-bit voltage DAC. A host writes 16-bit command words over a three-wire serial port: an active-low frame strobe, a serial clock and a data line. The block brings the serial clock and the frame strobe into the system clock domain and detects their edges there. It then shifts in one frame and carries out the command that the frame holds.

Each channel has two registers. A staged register takes incoming data, and a live register drives the channel code outputs. Commands can stage one channel, stage one channel and then copy every staged value to the live registers, broadcast one value to all channels, or put the whole converter to sleep. In sleep, the address field of the frame chooses how the outputs are terminated. The analog string, the amplifiers and the termination resistors sit outside this block. They are driven from `ch_code_*`, `pd_active` and `term_sel`.

The receiver is a three-state machine. `RX_IDLE` waits for the strobe to go low, which is the transition *open*. `RX_SHIFT` samples a data bit on every falling serial clock edge. It leaves by *complete*, which is the 16th falling edge and moves to `RX_HOLD` while issuing the command. It can also leave by *abort*, which is a strobe rise that returns it to `RX_IDLE`. `RX_HOLD` ignores every further clock edge until the strobe rises, which is the transition *close* back to `RX_IDLE`.

Top module: `qdac_cmd_decoder`

## Requirements
- R1: After reset, all four channel codes are 0, `pd_active` is 0 and `term_sel` is 2'b00.
- R2: A frame is 16 bits, sent MSB first and sampled on falling serial clock edges while the strobe is low. Bits [15:14] are the channel address (0=ch0, 1=ch1, 2=ch2, 3=ch3), bits [13:12] are the operation, and bits [11:0] are data. A channel code takes data bits [11:2], and data bits [1:0] are ignored.
- R3: Operation 2'b00 writes the staged register of the addressed channel and leaves all four channel code outputs unchanged.
- R4: Operation 2'b01 writes the staged register of the addressed channel. In the same step it copies all four staged values to the outputs, so values staged by earlier 2'b00 frames appear too.
- R5: Operation 2'b10 writes the frame's code to all four staged registers and to all four outputs.
- R6: Operation 2'b11 sets `pd_active` and leaves the channel codes unchanged. `term_sel` becomes 2'b00 (high impedance) for address 0 or 3, 2'b01 (low-ohm pull to ground) for address 1, and 2'b10 (high-ohm pull to ground) for address 2.
- R7: A complete frame with any operation other than 2'b11 clears `pd_active`. The clear happens in the same cycle that applies that frame's register action, and `term_sel` keeps its value.
- R8: If the strobe rises before the 16th falling edge, the frame is dropped. No register, no output, `pd_active` and `term_sel` all stay unchanged.
- R9: Exactly one command executes per frame. Falling edges and data after the 16th edge are ignored until the strobe returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock, asynchronous to `clk` |
| fsync_n_in | input | 1 | Active-low frame strobe |
| sdata_in | input | 1 | Serial data |
| ch_code_0 | output | 10 | Live code, channel 0 |
| ch_code_1 | output | 10 | Live code, channel 1 |
| ch_code_2 | output | 10 | Live code, channel 2 |
| ch_code_3 | output | 10 | Live code, channel 3 |
| pd_active | output | 1 | Converter is in power-down |
| term_sel | output | 2 | Output termination selection |

## Verification
The staged registers are hard to observe because no port shows them. A 2'b00 write can only be seen when a later 2'b01 frame copies it to the outputs. The stimulus therefore stages two channels, goes through a sleep command, and then sends a 2'b01 frame to a third channel, which shows the staged values and the clearing of `pd_active` together. The frames that are dropped or overrun are built by stopping the serial clock after ten bits, or by sending 32 bits under one strobe, and each is followed by a state comparison.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    parameter int NCH        = 4;
    parameter int CODE_W     = 10;
    parameter int FRAME_W    = 16;
    parameter int DATA_W     = 12;
    localparam int ADDR_W    = $clog2(NCH);

    typedef enum logic [1:0] {
        OP_STAGE      = 2'b00,
        OP_STAGE_LOAD = 2'b01,
        OP_BROADCAST  = 2'b10,
        OP_SLEEP      = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        TERM_OPEN = 2'b00,
        TERM_LOW  = 2'b01,
        TERM_HIGH = 2'b10
    } term_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'b00,
        RX_SHIFT = 2'b01,
        RX_HOLD  = 2'b10
    } rx_state_e;
endpackage

// File: rtl/qdac_in_sync.sv
module qdac_in_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
    import qdac_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          fsync_n_s,
    input  logic          sdata_s,
    output logic          cmd_valid,
    output logic [FW-1:0] cmd_word
);
    localparam int CNT_W = $clog2(FW);

    rx_state_e  state, state_nx;
    logic       sclk_d;
    logic       fall;
    logic [CNT_W-1:0] bit_cnt;
    logic [FW-1:0]    shreg;
    logic       last_bit;

    assign fall     = sclk_d && !sclk_s;
    assign last_bit = (bit_cnt == CNT_W'(FW-1));

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (!fsync_n_s) state_nx = RX_SHIFT;
            RX_SHIFT: begin
                if (fsync_n_s)              state_nx = RX_IDLE;
                else if (fall && last_bit)  state_nx = RX_HOLD;
            end
            RX_HOLD:  if (fsync_n_s) state_nx = RX_IDLE;
            default:  state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d    <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            cmd_valid <= 1'b0;
            cmd_word  <= '0;
        end else begin
            sclk_d    <= sclk_s;
            cmd_valid <= 1'b0;
            unique case (state)
                RX_IDLE: bit_cnt <= '0;
                RX_SHIFT: begin
                    if (!fsync_n_s && fall) begin
                        shreg   <= {shreg[FW-2:0], sdata_s};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (last_bit) begin
                            cmd_valid <= 1'b1;
                            cmd_word  <= {shreg[FW-2:0], sdata_s};
                        end
                    end
                end
                RX_HOLD: bit_cnt <= '0;
                default: bit_cnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/qdac_reg_bank.sv
module qdac_reg_bank
    import qdac_pkg::*;
#(
    parameter int N  = NCH,
    parameter int CW = CODE_W,
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [FW-1:0] cmd_word,
    output logic [CW-1:0] live [N],
    output logic          pd_active,
    output logic [1:0]    term_sel
);
    localparam int AW   = $clog2(N);
    localparam int DLSB = FW - AW - 2 - DATA_W;

    logic [AW-1:0] addr;
    op_e           op;
    logic [CW-1:0] code;
    logic [CW-1:0] staged [N];
    term_e         term_pick;

    assign addr = cmd_word[FW-1 -: AW];
    assign op   = op_e'(cmd_word[FW-AW-1 -: 2]);
    assign code = cmd_word[DLSB+DATA_W-1 -: CW];

    always_comb begin
        unique case (addr)
            AW'(1):  term_pick = TERM_LOW;
            AW'(2):  term_pick = TERM_HIGH;
            default: term_pick = TERM_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                staged[i] <= '0;
                live[i]   <= '0;
            end
            pd_active <= 1'b0;
            term_sel  <= TERM_OPEN;
        end else if (cmd_valid) begin
            unique case (op)
                OP_STAGE: begin
                    staged[addr] <= code;
                    pd_active    <= 1'b0;
                end
                OP_STAGE_LOAD: begin
                    staged[addr] <= code;
                    for (int i = 0; i < N; i++)
                        live[i] <= (AW'(i) == addr) ? code : staged[i];
                    pd_active <= 1'b0;
                end
                OP_BROADCAST: begin
                    for (int i = 0; i < N; i++) begin
                        staged[i] <= code;
                        live[i]   <= code;
                    end
                    pd_active <= 1'b0;
                end
                OP_SLEEP: begin
                    pd_active <= 1'b1;
                    term_sel  <= term_pick;
                end
                default: pd_active <= pd_active;
            endcase
        end
    end
endmodule

// File: rtl/qdac_cmd_decoder.sv
module qdac_cmd_decoder
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              fsync_n_in,
    input  logic              sdata_in,
    output logic [CODE_W-1:0] ch_code_0,
    output logic [CODE_W-1:0] ch_code_1,
    output logic [CODE_W-1:0] ch_code_2,
    output logic [CODE_W-1:0] ch_code_3,
    output logic              pd_active,
    output logic [1:0]        term_sel
);
    logic [2:0]         sync_q;
    logic               cmd_valid;
    logic [FRAME_W-1:0] cmd_word;
    logic [CODE_W-1:0]  live [NCH];

    qdac_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_in, fsync_n_in, sdata_in}),
        .q     (sync_q)
    );

    qdac_frame_rx #(.FW(FRAME_W)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sync_q[2]),
        .fsync_n_s (sync_q[1]),
        .sdata_s   (sync_q[0]),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word)
    );

    qdac_reg_bank #(.N(NCH), .CW(CODE_W), .FW(FRAME_W)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .live      (live),
        .pd_active (pd_active),
        .term_sel  (term_sel)
    );

    assign ch_code_0 = live[0];
    assign ch_code_1 = live[1];
    assign ch_code_2 = live[2];
    assign ch_code_3 = live[3];
endmodule

// File: rtl/qdac_cmd_checker.sv
module qdac_cmd_checker
    import qdac_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [FRAME_W-1:0] cmd_word,
    input logic [CODE_W-1:0]  ch_code_0,
    input logic [CODE_W-1:0]  ch_code_1,
    input logic [CODE_W-1:0]  ch_code_2,
    input logic [CODE_W-1:0]  ch_code_3,
    input logic               pd_active,
    input logic [1:0]         term_sel
);
    logic [4*CODE_W-1:0] codes;
    logic [1:0]          op_f;
    logic [CODE_W-1:0]   code_f;

    assign codes  = {ch_code_3, ch_code_2, ch_code_1, ch_code_0};
    assign op_f   = cmd_word[13:12];
    assign code_f = cmd_word[11:2];

    p_hold_no_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(codes) && $stable(pd_active) && $stable(term_sel)));

    p_single_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_stage_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op_f == 2'b00) |=> $stable(codes));

    p_broadcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op_f == 2'b10) |=>
        (ch_code_0 == $past(code_f) && ch_code_1 == $past(code_f) &&
         ch_code_2 == $past(code_f) && ch_code_3 == $past(code_f)));

    p_sleep_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op_f == 2'b11) |=> (pd_active && $stable(codes)));

    p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op_f != 2'b11) |=> (!pd_active && $stable(term_sel)));

    p_term_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        term_sel != 2'b11);
endmodule

bind qdac_cmd_decoder qdac_cmd_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .ch_code_0 (ch_code_0),
    .ch_code_1 (ch_code_1),
    .ch_code_2 (ch_code_2),
    .ch_code_3 (ch_code_3),
    .pd_active (pd_active),
    .term_sel  (term_sel)
);

// File: tb/qdac_cmd_decoder_tb.sv
module qdac_cmd_decoder_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_in = 1'b0;
    logic fsync_n_in = 1'b1;
    logic sdata_in = 1'b0;
    logic [9:0] ch_code_0, ch_code_1, ch_code_2, ch_code_3;
    logic pd_active;
    logic [1:0] term_sel;

    int checks = 0;
    int errors = 0;

    logic [9:0] m_pend [4];
    logic [9:0] m_act  [4];
    logic       m_pd;
    logic [1:0] m_term;

    always #5 clk = ~clk;

    qdac_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .fsync_n_in(fsync_n_in),
        .sdata_in(sdata_in), .ch_code_0(ch_code_0), .ch_code_1(ch_code_1),
        .ch_code_2(ch_code_2), .ch_code_3(ch_code_3), .pd_active(pd_active),
        .term_sel(term_sel)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_apply(input logic [15:0] w);
        logic [1:0] a = w[15:14];
        logic [1:0] op = w[13:12];
        logic [9:0] c = w[11:2];
        case (op)
            2'b00: begin m_pend[a] = c; m_pd = 1'b0; end
            2'b01: begin m_pend[a] = c; for (int i = 0; i < 4; i++) m_act[i] = m_pend[i]; m_pd = 1'b0; end
            2'b10: begin for (int i = 0; i < 4; i++) begin m_pend[i] = c; m_act[i] = c; end m_pd = 1'b0; end
            default: begin m_pd = 1'b1; m_term = (a == 2'd1) ? 2'b01 : (a == 2'd2) ? 2'b10 : 2'b00; end
        endcase
    endtask

    // Send nbits of w (MSB first), then optional extra bits of x, then raise strobe.
    task automatic send_bits(input logic [15:0] w, input int nbits,
                             input logic [15:0] x, input int xbits);
        @(negedge clk);
        fsync_n_in = 1'b0;
        wait_clks(4);
        for (int i = 0; i < nbits; i++) begin
            sclk_in = 1'b1; sdata_in = w[15-i];
            wait_clks(4);
            sclk_in = 1'b0;
            wait_clks(4);
        end
        for (int i = 0; i < xbits; i++) begin
            sclk_in = 1'b1; sdata_in = x[15-i];
            wait_clks(4);
            sclk_in = 1'b0;
            wait_clks(4);
        end
        sdata_in = 1'b0;
        fsync_n_in = 1'b1;
        wait_clks(10);
    endtask

    task automatic send_frame(input logic [15:0] w);
        send_bits(w, 16, 16'h0, 0);
        model_apply(w);
    endtask

    task automatic check_state(input string req);
        logic [9:0] got [4];
        got[0] = ch_code_0; got[1] = ch_code_1; got[2] = ch_code_2; got[3] = ch_code_3;
        for (int i = 0; i < 4; i++) begin
            checks++;
            if (got[i] !== m_act[i]) begin
                errors++;
                $display("FAIL %s ch%0d code actual %h expected %h", req, i, got[i], m_act[i]);
            end
        end
        checks++;
        if (pd_active !== m_pd) begin
            errors++;
            $display("FAIL %s pd_active actual %b expected %b", req, pd_active, m_pd);
        end
        checks++;
        if (term_sel !== m_term) begin
            errors++;
            $display("FAIL %s term_sel actual %b expected %b", req, term_sel, m_term);
        end
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) begin m_pend[i] = '0; m_act[i] = '0; end
        m_pd = 1'b0; m_term = 2'b00;
        check_state("R1 reset");
    endtask

    task automatic t_stage_only;
        send_frame({2'd2, 2'b00, 10'h2A5, 2'b00});
        check_state("R3 stage keeps outputs");
    endtask

    task automatic t_stage_load;
        send_frame({2'd0, 2'b01, 10'h113, 2'b00});
        check_state("R4 load shows staged ch2, R2 field layout");
    endtask

    task automatic t_lsb_ignored;
        send_frame({2'd3, 2'b01, 10'h3FF, 2'b11});
        check_state("R2 data bits [1:0] ignored");
        send_frame({2'd1, 2'b01, 10'h001, 2'b10});
        check_state("R2 low code with dont-care bits");
    endtask

    task automatic t_broadcast;
        send_frame({2'd1, 2'b10, 10'h155, 2'b01});
        check_state("R5 broadcast");
    endtask

    task automatic t_sleep_modes;
        send_frame({2'd1, 2'b00, 10'h0AA, 2'b00});
        send_frame({2'd3, 2'b00, 10'h300, 2'b00});
        send_frame({2'd1, 2'b11, 12'h000});
        check_state("R6 sleep addr1 low-ohm");
        send_frame({2'd2, 2'b11, 12'hFFF});
        check_state("R6 sleep addr2 high-ohm");
        send_frame({2'd3, 2'b11, 12'h000});
        check_state("R6 sleep addr3 open");
        send_frame({2'd2, 2'b11, 12'h000});
        send_frame({2'd0, 2'b11, 12'h000});
        check_state("R6 sleep addr0 open");
    endtask

    task automatic t_wake;
        send_frame({2'd1, 2'b11, 12'h000});
        send_frame({2'd2, 2'b01, 10'h2F0, 2'b00});
        check_state("R7 wake with load, staged ch1 ch3 shown");
    endtask

    task automatic t_abort;
        send_frame({2'd2, 2'b11, 12'h000});
        send_bits({2'd0, 2'b10, 10'h3C3, 2'b00}, 10, 16'h0, 0);
        check_state("R8 abort keeps sleep and codes");
        send_bits({2'd1, 2'b01, 10'h011, 2'b00}, 15, 16'h0, 0);
        check_state("R8 abort after 15 bits");
        send_frame({2'd0, 2'b01, 10'h0F0, 2'b00});
        check_state("R8 staged registers untouched by aborts");
    endtask

    task automatic t_overrun;
        send_bits({2'd3, 2'b10, 10'h1E1, 2'b00}, 16, {2'd0, 2'b10, 10'h2D2, 2'b00}, 16);
        model_apply({2'd3, 2'b10, 10'h1E1, 2'b00});
        check_state("R9 extra edges ignored");
        send_bits({2'd0, 2'b00, 10'h0AB, 2'b00}, 16, {2'd1, 2'b11, 12'h000}, 16);
        model_apply({2'd0, 2'b00, 10'h0AB, 2'b00});
        check_state("R9 trailing sleep not executed");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(5);
        t_reset();
        t_stage_only();
        t_stage_load();
        t_lsb_ignored();
        t_broadcast();
        t_sleep_modes();
        t_wake();
        t_abort();
        t_overrun();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule